// File: doc/BRIEF.md
# Decode-Stage Branch Redirect with Sign-Based Static Prediction

This block steers instruction fetch around conditional branches in a five-stage in-order pipeline. When the fetch stage sees an equal-compare or not-equal-compare branch, the block guesses the branch direction from the sign of the branch offset alone. A loop-closing branch (negative offset) is guessed taken. Every other branch is guessed not taken. The next fetch address is chosen from that guess in the same cycle. No history is kept, so the guess costs no storage.

One cycle later the branch sits in decode. There the block compares the two register operands that the register file supplies and checks the earlier guess. A correct guess costs nothing. A wrong guess costs one slot: the block pulses a flush that turns the single wrong-path instruction in the fetch/decode register into a no-op, and in the same cycle it redirects the PC to the correct address.

When the instruction directly ahead of the branch writes one of the branch's operands, the block holds the branch in decode for one cycle before comparing, and holds the PC during that cycle. Instruction memory, the register file and the operand-forwarding network lie outside the block.

Top module: `branch_redirect`

## Requirements
- R1: A branch in fetch (opcode 0x04 = branch-if-equal, 0x05 = branch-if-not-equal, bits [5:0]) whose 16-bit offset has bit 15 set drives nextPc = fetchPc + 4 + (sign-extended offset << 2), provided decode neither holds nor redirects in that cycle.
- R2: A branch in fetch whose offset is zero or positive drives nextPc = fetchPc + 4, provided decode neither holds nor redirects.
- R3: Any other opcode drives nextPc = fetchPc + 4 and never leads to a flush or mispredict one cycle later.
- R4: In decode, an opcode-0x04 branch counts as taken when decRsVal equals decRtVal, and an opcode-0x05 branch counts as taken when they differ.
- R5: A branch whose decode outcome matches its fetch guess raises neither flushFetch nor mispredict, and fetch continues with no lost cycle.
- R6: A branch whose outcome disagrees with its guess raises flushFetch and mispredict for exactly that cycle. nextPc becomes the branch's taken target if it is actually taken, and otherwise the branch's own PC + 4. The squashed instruction, even if it is itself a branch, is never resolved.
- R7: With a branch in decode and decDepHazard high, the first such cycle raises holdDecode, keeps nextPc = fetchPc and raises no flush. In the following cycle the branch resolves whatever decDepHazard is.
- R8: While reset is asserted and right after it ends, holdDecode, flushFetch and mispredict are low and a non-branch fetch gets nextPc = fetchPc + 4.
- R9: When a redirect in decode and a branch in fetch fall in the same cycle, the redirect chooses nextPc and the fetched branch's guess is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | 32 | Address of the instruction in fetch |
| fetchOp | input | 6 | Opcode of the instruction in fetch |
| fetchOffset | input | 16 | Branch offset field of the instruction in fetch (in words) |
| decRsVal | input | 32 | First register operand of the instruction in decode |
| decRtVal | input | 32 | Second register operand of the instruction in decode |
| decDepHazard | input | 1 | The instruction just ahead writes a register the decode instruction reads |
| nextPc | output | 32 | Address to fetch next |
| flushFetch | output | 1 | Clear the fetch/decode register to a no-op |
| mispredict | output | 1 | A branch guess was wrong this cycle |
| holdDecode | output | 1 | Hold the PC and the fetch/decode register for one cycle |

## Verification
A redirect from a wrong guess in decode and a fresh guess for a branch sitting in fetch can fall in the same cycle. Directed steps place a backward branch in fetch directly behind a mispredicted forward branch. A randomized run keeps producing such pairs by fetching from the block's own nextPc. The reference model judges each such cycle by checking that nextPc is the decode branch's corrected address, and that the squashed branch in fetch leaves no flush one cycle later.

// File: rtl/brpred_pkg.sv
package brpred_pkg;
  typedef struct packed {
    logic stall;       // hold PC and decode contents
    logic loadDec;     // capture the fetch-side branch data
    logic redirect;    // wrong guess resolved this cycle
    logic redirTaken;  // corrected direction of the resolved branch
    logic predTaken;   // fetch-side guess is taken
  } brStrobe_t;
endpackage

// File: rtl/brpred_dp.sv
module brpred_dp
  import brpred_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] fetchPc,
  input  logic [OFF_W-1:0] fetchOffset,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  input  brStrobe_t       strobe,
  output logic            fetchNeg,
  output logic            operandsEq,
  output logic [XLEN-1:0] nextPc
);
  localparam int SHIFT       = 2;
  localparam int EXT_W       = XLEN - OFF_W - SHIFT;
  localparam int INSTR_BYTES = 1 << SHIFT;

  logic [XLEN-1:0] offBytes;
  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] fetchTarget;
  logic [XLEN-1:0] decTarget;
  logic [XLEN-1:0] decFall;

  assign offBytes    = {{EXT_W{fetchOffset[OFF_W-1]}}, fetchOffset, {SHIFT{1'b0}}};
  assign seqPc       = fetchPc + XLEN'(INSTR_BYTES);
  assign fetchTarget = seqPc + offBytes;
  assign fetchNeg    = fetchOffset[OFF_W-1];
  assign operandsEq  = (rsVal == rtVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decTarget <= '0;
      decFall   <= '0;
    end else if (strobe.loadDec) begin
      decTarget <= fetchTarget;
      decFall   <= seqPc;
    end
  end

  always_comb begin
    if (strobe.stall)         nextPc = fetchPc;
    else if (strobe.redirect) nextPc = strobe.redirTaken ? decTarget : decFall;
    else if (strobe.predTaken) nextPc = fetchTarget;
    else                      nextPc = seqPc;
  end

  // R7: a held cycle keeps fetching the same address
  p_hold_keeps_pc_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stall |-> (nextPc == fetchPc));

  // R7: the captured branch addresses survive the hold unchanged
  p_hold_keeps_dec_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stall |=> ($stable(decTarget) && $stable(decFall)));
endmodule

// File: rtl/brpred_ctl.sv
module brpred_ctl
  import brpred_pkg::*;
#(
  parameter int OP_W  = 6,
  parameter int OP_EQ = 4,
  parameter int OP_NE = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] fetchOp,
  input  logic            fetchNeg,
  input  logic            operandsEq,
  input  logic            depHazard,
  output brStrobe_t       strobe
);
  logic fetchIsEq, fetchIsNe, fetchIsBr;
  logic decValid, decPred, decNe, heldOnce;
  logic resolve, actualTaken;

  assign fetchIsEq = (fetchOp == OP_W'(OP_EQ));
  assign fetchIsNe = (fetchOp == OP_W'(OP_NE));
  assign fetchIsBr = fetchIsEq | fetchIsNe;

  assign actualTaken = decNe ? !operandsEq : operandsEq;

  always_comb begin
    strobe.stall      = decValid && depHazard && !heldOnce;
    resolve           = decValid && !strobe.stall;
    strobe.redirect   = resolve && (actualTaken != decPred);
    strobe.redirTaken = actualTaken;
    strobe.loadDec    = !strobe.stall;
    strobe.predTaken  = fetchIsBr && fetchNeg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid <= 1'b0;
      decPred  <= 1'b0;
      decNe    <= 1'b0;
      heldOnce <= 1'b0;
    end else begin
      heldOnce <= strobe.stall;
      if (strobe.loadDec) begin
        decValid <= fetchIsBr && !strobe.redirect;
        decPred  <= fetchNeg;
        decNe    <= fetchIsNe;
      end
    end
  end

  // R7: a branch is held for at most one cycle
  p_single_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stall |=> !strobe.stall);

  // R6: the squashed slot never resolves as a branch
  p_squash_slot_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.redirect |=> !strobe.redirect);
endmodule

// File: rtl/branch_redirect.sv
module branch_redirect
  import brpred_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int OP_W  = 6,
  parameter int OP_EQ = 4,
  parameter int OP_NE = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [XLEN-1:0]  fetchPc,
  input  logic [OP_W-1:0]  fetchOp,
  input  logic [OFF_W-1:0] fetchOffset,
  input  logic [XLEN-1:0]  decRsVal,
  input  logic [XLEN-1:0]  decRtVal,
  input  logic             decDepHazard,
  output logic [XLEN-1:0]  nextPc,
  output logic             flushFetch,
  output logic             mispredict,
  output logic             holdDecode
);
  brStrobe_t strobe;
  logic      fetchNeg;
  logic      operandsEq;

  brpred_ctl #(.OP_W(OP_W), .OP_EQ(OP_EQ), .OP_NE(OP_NE)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchOp    (fetchOp),
    .fetchNeg   (fetchNeg),
    .operandsEq (operandsEq),
    .depHazard  (decDepHazard),
    .strobe     (strobe)
  );

  brpred_dp #(.XLEN(XLEN), .OFF_W(OFF_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .fetchPc     (fetchPc),
    .fetchOffset (fetchOffset),
    .rsVal       (decRsVal),
    .rtVal       (decRtVal),
    .strobe      (strobe),
    .fetchNeg    (fetchNeg),
    .operandsEq  (operandsEq),
    .nextPc      (nextPc)
  );

  assign flushFetch = strobe.redirect;
  assign mispredict = strobe.redirect;
  assign holdDecode = strobe.stall;

  // R7, R6: a hold cycle never flushes
  p_hold_no_flush_r7: assert property (@(posedge clk) disable iff (!rstN)
    holdDecode |-> !flushFetch);
endmodule

// File: tb/branch_redirect_test.sv
`timescale 1ns/1ps
module branch_redirect_test;
  localparam int OP_EQ = 4;
  localparam int OP_NE = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0;
  logic [5:0]  fetchOp = '0;
  logic [15:0] fetchOffset = '0;
  logic [31:0] decRsVal = '0;
  logic [31:0] decRtVal = '0;
  logic        decDepHazard = 1'b0;
  logic [31:0] nextPc;
  logic        flushFetch, mispredict, holdDecode;

  int checks = 0;
  int failures = 0;

  // reference model state: branches waiting in decode
  bit          mValid = 0, mPred = 0, mNe = 0, mHeld = 0;
  logic [31:0] mTarget = '0, mFall = '0;
  logic [31:0] lastNext = 32'h1000;

  always #2 clk = ~clk;

  branch_redirect uut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .fetchOp(fetchOp),
    .fetchOffset(fetchOffset), .decRsVal(decRsVal), .decRtVal(decRtVal),
    .decDepHazard(decDepHazard), .nextPc(nextPc), .flushFetch(flushFetch),
    .mispredict(mispredict), .holdDecode(holdDecode)
  );

  task automatic step(input logic [5:0] op, input logic [15:0] off,
                      input logic [31:0] pc, input logic [31:0] rs,
                      input logic [31:0] rt, input bit dep);
    bit eStall, resolve, act, eMis, isBr, neg;
    logic [31:0] seq, tgt, eNext;
    string tag;
    @(negedge clk);
    fetchOp = op; fetchOffset = off; fetchPc = pc;
    decRsVal = rs; decRtVal = rt; decDepHazard = dep;
    #1;
    isBr    = (op == 6'(OP_EQ)) || (op == 6'(OP_NE));
    neg     = off[15];
    seq     = pc + 32'd4;
    tgt     = seq + {{14{off[15]}}, off, 2'b00};
    eStall  = mValid && dep && !mHeld;
    resolve = mValid && !eStall;
    act     = mNe ? (rs != rt) : (rs == rt);
    eMis    = resolve && (act != mPred);
    if (eStall)               eNext = pc;
    else if (eMis)            eNext = act ? mTarget : mFall;
    else if (isBr && neg)     eNext = tgt;
    else                      eNext = seq;
    if (eStall)               tag = "R7";
    else if (eMis)            tag = isBr ? "R9 R6 R4" : "R6 R4";
    else if (resolve)         tag = "R5 R4";
    else if (isBr)            tag = neg ? "R1" : "R2";
    else                      tag = "R3";
    checks++;
    if (nextPc !== eNext || flushFetch !== eMis || mispredict !== eMis ||
        holdDecode !== eStall) begin
      failures++;
      $display("FAIL %s: nextPc=%h flush=%b mis=%b hold=%b expected nextPc=%h flush=%b mis=%b hold=%b",
               tag, nextPc, flushFetch, mispredict, holdDecode, eNext, eMis, eMis, eStall);
    end
    lastNext = eNext;
    @(posedge clk);
    if (!eStall) begin
      mValid = isBr && !eMis; mPred = neg; mNe = (op == 6'(OP_NE));
      mTarget = tgt; mFall = seq;
    end
    mHeld = eStall;
  endtask

  initial begin
    #(4ns * 150000);
    failures++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R8: quiet while reset is held
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (flushFetch !== 1'b0 || mispredict !== 1'b0 || holdDecode !== 1'b0) begin
      failures++;
      $display("FAIL R8: flush=%b mis=%b hold=%b expected 0 0 0", flushFetch, mispredict, holdDecode);
    end
    rstN = 1'b1;
    // R8 / R3: first fetch after reset is sequential
    step(6'd0, 16'h0000, 32'h100, 0, 0, 0);
    // R1: backward beq guessed taken -> 0x108 - 16 = 0xF8
    step(6'(OP_EQ), 16'hFFFC, 32'h104, 0, 0, 0);
    // R5: resolves taken, matches guess
    step(6'd0, 16'h0000, 32'hF8, 32'h7, 32'h7, 0);
    // R2: forward beq guessed not taken
    step(6'(OP_EQ), 16'h0008, 32'h200, 0, 0, 0);
    // R6/R9: resolves taken -> 0x224, fetched backward bne squashed
    step(6'(OP_NE), 16'hFFF0, 32'h204, 32'h3, 32'h3, 0);
    // R6: squashed branch must not resolve
    step(6'd0, 16'h0000, 32'h224, 32'h1, 32'h2, 0);
    // R1 then R6: backward bne resolves not taken -> fall-through 0x304
    step(6'(OP_NE), 16'hFFFE, 32'h300, 0, 0, 0);
    step(6'd0, 16'h0000, 32'h2FC, 32'h9, 32'h9, 0);
    // R7: hold once then resolve despite hazard still high
    step(6'(OP_EQ), 16'h0004, 32'h400, 0, 0, 0);
    step(6'd0, 16'h0000, 32'h404, 32'h1, 32'h1, 1);
    step(6'd0, 16'h0000, 32'h404, 32'h1, 32'h1, 1);
    // R2: zero offset bne guessed not taken, resolves not taken (R5)
    step(6'(OP_NE), 16'h0000, 32'h500, 0, 0, 0);
    step(6'd0, 16'h0000, 32'h504, 32'h5, 32'h5, 0);
    // R3: non-branch followed by no flush
    step(6'd9, 16'h8000, 32'h600, 0, 0, 0);
    step(6'd0, 16'h0000, 32'h604, 32'h1, 32'h2, 0);
    // randomized stream fetching from the block's own nextPc
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      logic [15:0] off;
      int sel;
      sel = $urandom_range(0, 3);
      op  = (sel == 0) ? 6'(OP_EQ) : (sel == 1) ? 6'(OP_NE) : (sel == 2) ? 6'd9 : 6'd0;
      off = 16'($signed($urandom_range(0, 64)) - 32);
      step(op, off, lastNext, 32'($urandom_range(0, 2)), 32'($urandom_range(0, 2)),
           ($urandom_range(0, 3) == 0));
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule